// File: doc/BRIEF.md
# Receive Symbol Packer, Four Lanes of Ten Bits

The block sits behind a single serial receive channel. One 10-bit code symbol arrives per clock, qualified by a valid strobe. The block gathers four accepted symbols into one packed group. The low byte of each symbol goes into a 32-bit data word. The two upper bits of each symbol are steered into two separate 4-bit side vectors, one bit per lane. When a group is complete, the block registers it and raises a one-clock output strobe. The packed word then stays on the outputs until the next group completes.

The earliest symbol of a group takes the most significant lane. A restart input throws away a partly built group, so that downstream alignment logic can move the group boundary. Reset is synchronous and active high.

Top module: `rxp_pack_top`

## Requirements
- R1: Within a group, the first accepted symbol's bits [7:0] appear on out_data[31:24]. The second symbol's appear on [23:16], the third's on [15:8] and the fourth's on [7:0]. Lane n occupies out_data[8n+7:8n].
- R2: Symbol bit 8 of lane n appears on out_bit8[n], and symbol bit 9 of lane n appears on out_bit9[n].
- R3: A cycle with sym_valid low has no effect on the group being built. Only accepted symbols advance the lane position.
- R4: out_valid is high for exactly one clock, in the cycle after the clock edge that accepts a group's fourth symbol. With a gap-free stream, the word appears four clocks after the first symbol is presented.
- R5: A restart with sym_valid low discards the partial group. The next accepted symbol becomes the first symbol (lane 3) of a new group.
- R6: A restart together with sym_valid high discards the partial group, and that same symbol becomes lane 3 of the new group.
- R7: out_data, out_bit8 and out_bit9 keep their values in every cycle where out_valid is low.
- R8: Reset clears out_valid, out_data, out_bit8, out_bit9 and any partial group, so the next accepted symbol is lane 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Discard the partial group and start a new one |
| sym_valid | input | 1 | The sym input holds a symbol this cycle |
| sym | input | 10 | Received code symbol |
| out_valid | output | 1 | One-clock strobe for a completed group |
| out_data | output | 32 | Low bytes of the four lanes, earliest symbol in the most significant lane |
| out_bit8 | output | 4 | Bit 8 of each lane's symbol |
| out_bit9 | output | 4 | Bit 9 of each lane's symbol |

## Verification
Each input is driven on a falling edge and is accepted on the following rising edge. A completed group is registered at that rising edge, so out_valid and the packed word are sampled on the next falling edge. That falling edge is one clock after the fourth symbol is presented, and four clocks after the first symbol of a gap-free group. On every step, the bench checks the strobe and all three output fields against a reference model of lane position and lane contents. In cycles without a strobe, the bench checks that all three fields still hold the last expected group. A separate measurement counts the cycles from the first presented symbol to the strobe.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int CNT_W  = $clog2(LANES);
    localparam int WORD_W = LANES * BYTE_W;

    typedef struct packed {
        logic              b9;
        logic              b8;
        logic [BYTE_W-1:0] byte_v;
    } sym_t;

    function automatic sym_t to_sym(input logic [SYM_W-1:0] raw);
        sym_t s;
        s.b9     = raw[9];
        s.b8     = raw[8];
        s.byte_v = raw[BYTE_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/rxp_lane_ctr.sv
module rxp_lane_ctr #(
    parameter int LANES = rxp_pkg::LANES,
    localparam int CW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          valid,
    output logic [CW-1:0] lane,
    output logic          last
);
    localparam logic [CW-1:0] TOP = CW'(LANES - 1);

    logic [CW-1:0] cnt;

    assign lane = restart ? TOP : cnt;
    assign last = valid && (lane == '0);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= TOP;
        else if (valid)   cnt <= (lane == '0) ? TOP : lane - 1'b1;
        else if (restart) cnt <= TOP;
    end

    // R5: an idle restart leaves the next symbol aimed at the top lane
    a_r5_idle_restart: assert property (@(posedge clk) disable iff (rst)
        (restart && !valid) |=> (lane == TOP));
    // R3: an idle cycle does not move the lane position
    a_r3_gap_holds: assert property (@(posedge clk) disable iff (rst)
        (!valid && !restart) |=> $stable(cnt));
endmodule

// File: rtl/rxp_lane_hold.sv
module rxp_lane_hold #(
    parameter int LANES = rxp_pkg::LANES,
    localparam int CW = $clog2(LANES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            valid,
    input  logic [CW-1:0]                   lane,
    input  rxp_pkg::sym_t                   sym_in,
    output rxp_pkg::sym_t [LANES-1:1]       held
);
    for (genvar n = 1; n < LANES; n++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)                              held[n] <= '0;
            else if (valid && lane == CW'(n))     held[n] <= sym_in;
        end
    end
endmodule

// File: rtl/rxp_out_reg.sv
module rxp_out_reg #(
    parameter int LANES  = rxp_pkg::LANES,
    parameter int BYTE_W = rxp_pkg::BYTE_W,
    localparam int WW = LANES * BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      last,
    input  rxp_pkg::sym_t             sym_in,
    input  rxp_pkg::sym_t [LANES-1:1] held,
    output logic [WW-1:0]             data,
    output logic [LANES-1:0]          b8,
    output logic [LANES-1:0]          b9,
    output logic                      valid
);
    rxp_pkg::sym_t [LANES-1:0] lanes;
    logic [WW-1:0]    nxt_data;
    logic [LANES-1:0] nxt_b8, nxt_b9;

    assign lanes[0] = sym_in;
    for (genvar n = 1; n < LANES; n++) begin : g_src
        assign lanes[n] = held[n];
    end

    for (genvar n = 0; n < LANES; n++) begin : g_pack
        assign nxt_data[n*BYTE_W +: BYTE_W] = lanes[n].byte_v;
        assign nxt_b8[n] = lanes[n].b8;
        assign nxt_b9[n] = lanes[n].b9;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            b8    <= '0;
            b9    <= '0;
            valid <= 1'b0;
        end else begin
            valid <= last;
            if (last) begin
                data <= nxt_data;
                b8   <= nxt_b8;
                b9   <= nxt_b9;
            end
        end
    end

    // R4: the strobe never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R7: fields are frozen whenever no group is being presented
    a_r7_hold_fields: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(data) && $stable(b8) && $stable(b9)));
    // R8: reset empties the outputs
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!valid && data == '0 && b8 == '0 && b9 == '0));
endmodule

// File: rtl/rxp_pack_top.sv
module rxp_pack_top (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        sym_valid,
    input  logic [9:0]  sym,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic [3:0]  out_bit8,
    output logic [3:0]  out_bit9
);
    import rxp_pkg::*;

    logic [CNT_W-1:0]  lane;
    logic              last;
    sym_t              s_in;
    sym_t [LANES-1:1]  held;

    assign s_in = to_sym(sym);

    rxp_lane_ctr #(.LANES(LANES)) u_ctr (
        .clk(clk), .rst(rst), .restart(restart), .valid(sym_valid),
        .lane(lane), .last(last)
    );

    rxp_lane_hold #(.LANES(LANES)) u_hold (
        .clk(clk), .rst(rst), .valid(sym_valid), .lane(lane),
        .sym_in(s_in), .held(held)
    );

    rxp_out_reg #(.LANES(LANES), .BYTE_W(BYTE_W)) u_out (
        .clk(clk), .rst(rst), .last(last), .sym_in(s_in), .held(held),
        .data(out_data), .b8(out_bit8), .b9(out_bit9), .valid(out_valid)
    );

    // R3: a group can only complete on a cycle that carried a symbol
    a_r3_strobe_needs_symbol: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(sym_valid));
endmodule

// File: tb/sim_rxp_pack_top.sv
module sim_rxp_pack_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        sym_valid = 1'b0;
    logic [9:0]  sym = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_bit8, out_bit9;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_pulse_cyc = 0;

    int          m_lane = 3;
    logic [9:0]  m_buf [4];
    logic        exp_v = 1'b0;
    logic [31:0] exp_data = '0;
    logic [3:0]  exp_b8 = '0, exp_b9 = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rxp_pack_top u0 (
        .clk(clk), .rst(rst), .restart(restart), .sym_valid(sym_valid), .sym(sym),
        .out_valid(out_valid), .out_data(out_data),
        .out_bit8(out_bit8), .out_bit9(out_bit9)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic rs, input logic [9:0] s, input string tag);
        string dtag;
        sym_valid = v;
        restart   = rs;
        sym       = s;
        @(posedge clk);
        if (rs) m_lane = 3;
        exp_v = 1'b0;
        if (v) begin
            m_buf[m_lane] = s;
            if (m_lane == 0) begin
                exp_v = 1'b1;
                for (int n = 0; n < 4; n++) begin
                    exp_data[n*8 +: 8] = m_buf[n][7:0];
                    exp_b8[n] = m_buf[n][8];
                    exp_b9[n] = m_buf[n][9];
                end
            end
            m_lane = (m_lane == 0) ? 3 : m_lane - 1;
        end
        @(negedge clk);
        dtag = exp_v ? tag : "R7";
        chk(out_valid === exp_v, exp_v ? tag : "R4", "out_valid", 32'(out_valid), 32'(exp_v));
        chk(out_data === exp_data, dtag, "out_data", out_data, exp_data);
        chk(out_bit8 === exp_b8, exp_v ? "R2" : "R7", "out_bit8", 32'(out_bit8), 32'(exp_b8));
        chk(out_bit9 === exp_b9, exp_v ? "R2" : "R7", "out_bit9", 32'(out_bit9), 32'(exp_b9));
        if (out_valid) last_pulse_cyc = cyc;
        sym_valid = 1'b0;
        restart   = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lane = 3; exp_v = 0; exp_data = '0; exp_b8 = '0; exp_b9 = '0;
        chk(out_valid === 1'b0, "R8", "out_valid", 32'(out_valid), 0);
        chk(out_data === '0, "R8", "out_data", out_data, 0);
        chk(out_bit8 === '0 && out_bit9 === '0, "R8", "side", {24'd0, out_bit9, out_bit8}, 0);
    endtask

    task automatic t_contig();
        int start;
        start = cyc;
        step(1, 0, 10'h1A5, "R1");
        step(1, 0, 10'h23C, "R1");
        step(1, 0, 10'h0F0, "R1");
        step(1, 0, 10'h30F, "R1");
        chk(out_data === 32'hA53CF00F, "R1", "lane order", out_data, 32'hA53CF00F);
        chk(out_bit8 === 4'b1001 && out_bit9 === 4'b0101, "R2", "side pattern",
            {24'd0, out_bit9, out_bit8}, {24'd0, 4'b0101, 4'b1001});
        chk((last_pulse_cyc - start) == 4, "R4", "latency", 32'(last_pulse_cyc - start), 4);
    endtask

    task automatic t_gaps();
        step(1, 0, 10'h155, "R3");
        step(0, 0, 10'h3FF, "R3");
        step(0, 0, 10'h2AA, "R3");
        step(1, 0, 10'h2AA, "R3");
        step(0, 0, 10'h000, "R3");
        step(1, 0, 10'h111, "R3");
        step(0, 0, 10'h1FF, "R3");
        step(1, 0, 10'h0C3, "R3");
        repeat (3) step(0, 0, 10'h3C3, "R7");
    endtask

    task automatic t_restart_idle();
        step(1, 0, 10'h3EE, "R5");
        step(1, 0, 10'h0DD, "R5");
        step(0, 1, 10'h000, "R5");
        step(1, 0, 10'h181, "R5");
        step(1, 0, 10'h242, "R5");
        step(1, 0, 10'h303, "R5");
        step(1, 0, 10'h004, "R5");
        chk(out_data === 32'h81420304, "R5", "realigned word", out_data, 32'h81420304);
    endtask

    task automatic t_restart_valid();
        step(1, 0, 10'h0AA, "R6");
        step(1, 0, 10'h0BB, "R6");
        step(1, 0, 10'h0CC, "R6");
        step(1, 1, 10'h211, "R6");
        step(1, 0, 10'h122, "R6");
        step(1, 0, 10'h033, "R6");
        step(1, 0, 10'h344, "R6");
        chk(out_data === 32'h11223344, "R6", "restart symbol lane3", out_data, 32'h11223344);
    endtask

    task automatic t_mid_reset();
        step(1, 0, 10'h3AB, "R8");
        step(1, 0, 10'h1CD, "R8");
        t_reset();
        repeat (4) step(1, 0, 10'h2E1, "R8");
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            step(($urandom % 3) != 0, 1'b0, 10'($urandom), "R1");
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_contig();
        t_gaps();
        t_restart_idle();
        t_restart_valid();
        t_mid_reset();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule